// File: doc/BRIEF.md
# Serial Nibble Register Port

This block is a slave serial control port. A host reaches a small file of 4-bit registers through four wires: an active-low select, a serial clock, a serial data input and a data output with a drive-enable. Each access is one 8-bit frame. The frame opens with a direction flag, then three address bits, then four data bits. Incoming bits are taken on rising clock edges. Read data leaves on falling edges.

Six registers can be read and written, and their contents are presented in parallel to the surrounding logic. A seventh holds a 4-bit code that the receive path supplies, and the host can only read it. The eighth address is unused. All logic runs on the serial clock and is cleared by an asynchronous active-low reset. Moving the register outputs into another clock domain is left to the logic that uses them.

Top module: `nibble_reg_port`

## Requirements
- R1: While `csN` is low, each rising edge of `sclk` takes one bit from `sdi`. The first bit is the direction (1 = read, 0 = write), the next three are the address with the most significant bit first, and the last four are data with the most significant bit first.
- R2: In a write frame, the eighth rising edge stores the four data bits in the addressed register. Register i appears on `cfgFlat[4*i+3:4*i]` for i = 0 to 5.
- R3: In a read frame, `sdoOe` goes high on the first falling edge after the fourth rising edge and `sdoData` carries data bit 3. Bits 2, 1 and 0 follow on the next three falling edges, and bit 0 then holds until `csN` rises.
- R4: `sdoOe` is low whenever `csN` is high, throughout every write frame, and during the direction and address bits of a read frame.
- R5: Bits on `sdi` during the data phase of a read frame change no register.
- R6: Address 6 returns `rxCode` as it stood at the fourth rising edge of the frame. A write to address 6 changes nothing.
- R7: Address 7 reads as 0000, and a write to it changes nothing.
- R8: Bit 0 of register 0 always reads 0, and writes to it are discarded.
- R9: While `rstN` is low, registers 0 to 5 return to their defaults, which are all zero with the default parameters, and `sdoOe` is low.
- R10: Raising `csN` partway through a frame abandons it. A write that has not reached its eighth rising edge is not stored, and the next frame starts again at the direction bit.
- R11: `sclk` edges while `csN` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock |
| csN | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data in |
| rxCode | input | 4 | Code supplied by the receive path, readable at address 6 |
| sdoData | output | 1 | Serial read data |
| sdoOe | output | 1 | Drive enable for the data-out pad |
| cfgFlat | output | 24 | Registers 0 to 5, four bits each, register 0 in the lowest bits |

## Verification
The hardest case to reach is a frame cut short when it is almost complete. A write abandoned one edge before it would be stored must leave no trace, and the next frame must decode from its first bit. The bench reaches this by raising `csN` after a chosen number of bits, both in a write and in the data phase of a read. It then reads a register whose contents it knows, which shows that the bit count restarted at zero. The capture instant for the read-only code is tested by changing `rxCode` after the fourth rising edge while the frame is still running.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  localparam int DATA_W = 4;
  localparam int ADDR_W = 3;
  localparam int BIT_W  = $clog2(DATA_W);

  // strobes from control to datapath, all decoded from the bit count
  typedef struct packed {
    logic              snap;     // address complete: capture read data
    logic              shiftIn;  // write data bit arriving
    logic              commit;   // last write bit arriving: store
    logic [ADDR_W-1:0] addr;     // target address
    logic              drive;    // read data phase: output enabled
    logic              advance;  // present a new bit on the next falling edge
    logic [BIT_W-1:0]  bitSel;   // which read bit to present
  } portStrobeT;
endpackage

// File: rtl/nrp_ctrl.sv
module nrp_ctrl
  import nrp_pkg::*;
(
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       sdi,
  output portStrobeT strb
);
  localparam int FRAME = 1 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [CNT_W-1:0]  bitCnt;
  logic              rwFlag;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] addrNow;
  logic [CNT_W-1:0]  dataOffs;

  // the count clears while the frame is deselected, so each frame starts at the direction bit
  always_ff @(posedge sclk or posedge csN or negedge rstN) begin
    if (!rstN || csN) begin
      bitCnt  <= '0;
      rwFlag  <= 1'b0;
      addrReg <= '0;
    end else begin
      if (bitCnt == '0)
        rwFlag <= sdi;
      if (bitCnt >= CNT_W'(1) && bitCnt <= CNT_W'(ADDR_W))
        addrReg <= addrNow;
      if (bitCnt < CNT_W'(FRAME))
        bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  assign addrNow  = {addrReg[ADDR_W-2:0], sdi};
  assign dataOffs = bitCnt - CNT_W'(ADDR_W + 1);

  always_comb begin
    strb.snap    = (bitCnt == CNT_W'(ADDR_W));
    strb.addr    = strb.snap ? addrNow : addrReg;
    strb.shiftIn = !rwFlag && bitCnt > CNT_W'(ADDR_W) && bitCnt < CNT_W'(FRAME);
    strb.commit  = !rwFlag && bitCnt == CNT_W'(FRAME - 1);
    strb.drive   = rwFlag && bitCnt > CNT_W'(ADDR_W);
    strb.advance = strb.drive && bitCnt < CNT_W'(FRAME);
    strb.bitSel  = BIT_W'(DATA_W - 1) - dataOffs[BIT_W-1:0];
  end
endmodule

// File: rtl/nrp_datapath.sv
module nrp_datapath
  import nrp_pkg::*;
#(
  parameter int                         NUM_RW     = 6,
  parameter logic [NUM_RW*DATA_W-1:0]   RESET_VALS = '0
) (
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       sdi,
  input  logic [DATA_W-1:0]          rxCode,
  input  portStrobeT                 strb,
  output logic                       sdoData,
  output logic                       sdoOe,
  output logic [NUM_RW*DATA_W-1:0]   cfgFlat
);
  localparam logic [ADDR_W-1:0] RO_ADDR = ADDR_W'(NUM_RW);

  logic [DATA_W-1:0] regs [NUM_RW];
  logic [DATA_W-1:0] wrShift;
  logic [DATA_W-1:0] wrWord;
  logic [DATA_W-1:0] rdSel;
  logic [DATA_W-1:0] rdHold;

  assign wrWord = {wrShift[DATA_W-2:0], sdi};

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN)
      wrShift <= '0;
    else if (strb.shiftIn)
      wrShift <= wrWord;
  end

  // one register per address; register 0 bit 0 has no function and is never stored
  for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP = (i == 0) ? ~DATA_W'(1) : {DATA_W{1'b1}};
    always_ff @(posedge sclk or negedge rstN) begin
      if (!rstN)
        regs[i] <= RESET_VALS[i*DATA_W +: DATA_W] & KEEP;
      else if (strb.commit && strb.addr == ADDR_W'(i))
        regs[i] <= wrWord & KEEP;
    end
    assign cfgFlat[i*DATA_W +: DATA_W] = regs[i];
  end

  always_comb begin
    rdSel = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (strb.addr == ADDR_W'(i))
        rdSel = regs[i];
    if (strb.addr == RO_ADDR)
      rdSel = rxCode;
  end

  // the read word is frozen when the address completes, so a moving code cannot tear
  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN)
      rdHold <= '0;
    else if (strb.snap)
      rdHold <= rdSel;
  end

  always_ff @(negedge sclk or posedge csN or negedge rstN) begin
    if (!rstN || csN) begin
      sdoOe   <= 1'b0;
      sdoData <= 1'b0;
    end else if (strb.drive) begin
      sdoOe <= 1'b1;
      if (strb.advance)
        sdoData <= rdHold[strb.bitSel];
    end
  end
endmodule

// File: rtl/nibble_reg_port.sv
module nibble_reg_port
  import nrp_pkg::*;
#(
  parameter int                       NUM_RW     = 6,
  parameter logic [NUM_RW*DATA_W-1:0] RESET_VALS = '0
) (
  input  logic                     rstN,
  input  logic                     sclk,
  input  logic                     csN,
  input  logic                     sdi,
  input  logic [DATA_W-1:0]        rxCode,
  output logic                     sdoData,
  output logic                     sdoOe,
  output logic [NUM_RW*DATA_W-1:0] cfgFlat
);
  portStrobeT strb;

  nrp_ctrl u_ctrl (
    .rstN (rstN),
    .sclk (sclk),
    .csN  (csN),
    .sdi  (sdi),
    .strb (strb)
  );

  nrp_datapath #(.NUM_RW(NUM_RW), .RESET_VALS(RESET_VALS)) u_dp (
    .rstN    (rstN),
    .sclk    (sclk),
    .csN     (csN),
    .sdi     (sdi),
    .rxCode  (rxCode),
    .strb    (strb),
    .sdoData (sdoData),
    .sdoOe   (sdoOe),
    .cfgFlat (cfgFlat)
  );
endmodule

// File: rtl/nrp_checker.sv
module nrp_checker #(
  parameter int NUM_RW = 6,
  parameter int CFG_W  = 24
) (
  input logic             rstN,
  input logic             sclk,
  input logic             csN,
  input logic             sdoOe,
  input logic             commit,
  input logic             drive,
  input logic [2:0]       addr,
  input logic [CFG_W-1:0] cfgFlat
);
  a_r4_quiet_when_deselected: assert property (@(posedge sclk) disable iff (!rstN)
    csN |-> !sdoOe);

  a_r4_quiet_outside_read_data: assert property (@(posedge sclk) disable iff (!rstN)
    !drive |-> !sdoOe);

  a_r3_enable_rises_in_data_phase: assert property (@(posedge sclk) disable iff (!rstN)
    $rose(sdoOe) |-> drive);

  // R6, R7, R5, R11: without a store to a writable address the registers hold
  a_r6_hold_without_store: assert property (@(posedge sclk) disable iff (!rstN)
    !(commit && addr < 3'(NUM_RW)) |=> $stable(cfgFlat));

  a_r8_dead_bit_after_store: assert property (@(posedge sclk) disable iff (!rstN)
    (commit && addr == 3'd0) |=> !cfgFlat[0]);
endmodule

bind nibble_reg_port nrp_checker #(.NUM_RW(NUM_RW), .CFG_W(NUM_RW*4)) u_chk (
  .rstN    (rstN),
  .sclk    (sclk),
  .csN     (csN),
  .sdoOe   (sdoOe),
  .commit  (strb.commit),
  .drive   (strb.drive),
  .addr    (strb.addr),
  .cfgFlat (cfgFlat)
);

// File: tb/tb_nibble_reg_port.sv
`timescale 1ns/100ps
module tb_nibble_reg_port;
  logic        rstN = 1'b0;
  logic        sclk = 1'b0;
  logic        csN  = 1'b1;
  logic        sdi  = 1'b0;
  logic [3:0]  rxCode = 4'h0;
  logic        sdoData;
  logic        sdoOe;
  logic [23:0] cfgFlat;

  int  runCnt  = 0;
  int  failCnt = 0;
  bit  finished = 0;

  nibble_reg_port dut (
    .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi), .rxCode(rxCode),
    .sdoData(sdoData), .sdoOe(sdoOe), .cfgFlat(cfgFlat)
  );

  always #2 sclk = ~sclk;

  // {rw, addr[2:0], wdata[3:0], expected[3:0]}
  localparam int NV = 16;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 3'd1, 4'hA, 4'h0}, {1'b1, 3'd1, 4'h0, 4'hA},
    {1'b0, 3'd2, 4'h5, 4'h0}, {1'b0, 3'd0, 4'hF, 4'h0},
    {1'b1, 3'd0, 4'h0, 4'hE}, {1'b0, 3'd6, 4'h9, 4'h0},
    {1'b1, 3'd6, 4'h0, 4'h3}, {1'b0, 3'd7, 4'hF, 4'h0},
    {1'b1, 3'd7, 4'h0, 4'h0}, {1'b1, 3'd2, 4'h0, 4'h5},
    {1'b0, 3'd4, 4'hC, 4'h0}, {1'b0, 3'd5, 4'h7, 4'h0},
    {1'b1, 3'd4, 4'h0, 4'hC}, {1'b1, 3'd5, 4'h0, 4'h7},
    {1'b0, 3'd3, 4'h1, 4'h0}, {1'b1, 3'd3, 4'h0, 4'h1}
  };
  localparam logic [23:0] CFG_AFTER = 24'h7C15AE;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one frame of up to eight bits; stops after 'bits' bits to model an abandoned frame
  task automatic frame(input logic rw, input logic [2:0] a, input logic [3:0] d,
                       input int bits, input bit chg, input logic [3:0] chgVal,
                       output logic [3:0] rd);
    logic [7:0] word;
    bit oeOk;
    word = {rw, a, d};
    rd   = 4'h0;
    oeOk = 1;
    @(negedge sclk); #1 csN = 1'b0;
    for (int i = 0; i < bits; i++) begin
      sdi = word[7-i];
      if (chg && i == 4) rxCode = chgVal;
      @(posedge sclk); @(negedge sclk); #1;
      if (rw && i >= 3) begin
        if (!sdoOe) oeOk = 0;
        if (i <= 6) rd[6-i] = sdoData;
      end else if (sdoOe) oeOk = 0;
    end
    csN = 1'b1;
    #0.5;
    check(oeOk, "R3/R4 output enable during frame", 32'(oeOk), 1);
    check(!sdoOe, "R4 output off after deselect", 32'(sdoOe), 0);
  endtask

  initial begin
    logic [3:0] rd;
    #11;
    check(cfgFlat == 24'h0, "R9 reset defaults", cfgFlat, 0);
    check(!sdoOe, "R4 output off in reset", 32'(sdoOe), 0);
    @(negedge sclk); #1 rstN = 1'b1;
    rxCode = 4'h3;

    // table walk: R1 R2 R3 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      frame(VEC[k][11], VEC[k][10:8], VEC[k][7:4], 8, 0, 4'h0, rd);
      if (VEC[k][11])
        check(rd == VEC[k][3:0], $sformatf("R1/R3 read addr %0d (R6 R7 R8)", VEC[k][10:8]), rd, VEC[k][3:0]);
    end
    check(cfgFlat == CFG_AFTER, "R2 parallel register image", cfgFlat, CFG_AFTER);

    // R10: write abandoned one bit before storing
    frame(1'b0, 3'd1, 4'h3, 7, 0, 4'h0, rd);
    check(cfgFlat == CFG_AFTER, "R10 abandoned write not stored", cfgFlat, CFG_AFTER);
    frame(1'b1, 3'd1, 4'h0, 8, 0, 4'h0, rd);
    check(rd == 4'hA, "R10 next frame restarts at direction bit", rd, 4'hA);
    // R10: read abandoned inside data phase
    frame(1'b1, 3'd4, 4'h0, 5, 0, 4'h0, rd);
    frame(1'b1, 3'd2, 4'h0, 8, 0, 4'h0, rd);
    check(rd == 4'h5, "R10 read after abandoned read", rd, 4'h5);

    // R11: clock and data toggling while deselected
    for (int k = 0; k < 20; k++) begin
      @(negedge sclk); #1 sdi = ~sdi;
    end
    check(cfgFlat == CFG_AFTER, "R11 deselected clocks ignored", cfgFlat, CFG_AFTER);
    check(!sdoOe, "R11 output off while deselected", 32'(sdoOe), 0);

    // R5: ones on the input during read data phase
    frame(1'b1, 3'd5, 4'hF, 8, 0, 4'h0, rd);
    check(rd == 4'h7, "R5 read value", rd, 4'h7);
    check(cfgFlat == CFG_AFTER, "R5 read data phase input ignored", cfgFlat, CFG_AFTER);

    // R6: code changes after capture instant
    frame(1'b1, 3'd6, 4'h0, 8, 1, 4'h9, rd);
    check(rd == 4'h3, "R6 code captured at fourth rising edge", rd, 4'h3);
    frame(1'b1, 3'd6, 4'h0, 8, 0, 4'h0, rd);
    check(rd == 4'h9, "R6 new code visible", rd, 4'h9);

    // R9: reset in mid run
    @(negedge sclk); #1 rstN = 1'b0;
    @(negedge sclk); #1;
    check(cfgFlat == 24'h0, "R9 reset restores defaults", cfgFlat, 0);
    rstN = 1'b1;
    frame(1'b1, 3'd4, 4'h0, 8, 0, 4'h0, rd);
    check(rd == 4'h0, "R9 register reads default", rd, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      runCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end
endmodule